// File: doc/BRIEF.md
# Dual-Clock FIFO with Programmable Threshold Flags

This block is a first-in first-out buffer whose write side and read side run on two unrelated clocks. Words of a configurable width (9 bits by default) enter on write-clock edges and leave, in the order they arrived, through an output register that is loaded on read-clock edges. The depth is a parameter. Four active-low status flags are produced: empty and almost-empty are registered on the read clock, and full and almost-full are registered on the write clock. The almost-empty and almost-full thresholds are taken from two offset inputs that a neighbouring block holds. That block resets them to 7 and lets software change them.

Each side keeps a binary pointer one bit wider than the address. The pointer crosses to the other clock as a Gray code through two flip-flops. Each side compares its own next pointer with the synchronised copy of the other pointer, so a flag can lag a change on the far side by a few cycles but is never optimistic. One shared control pin has two roles, and its level during reset selects which. If it is high during reset, it is a second write enable. If it is low during reset, the block is in offset-load mode: the pin then steers writes (and reads) between the FIFO and the neighbouring offset registers, and a mode output tells that block which role is active.

Top module: `dc_fifo_pflag`

## Requirements
- R1: While `rst_n` is low at a clock edge, both pointers return to zero. On the read side, `dout` clears to 0 and `empty_n` and `aempty_n` go low. On the write side, `full_n` and `afull_n` go high.
- R2: `load_mode` becomes 1 if `wr_aux` is low at the write-clock edges during reset, and 0 if `wr_aux` is high. It keeps that value until the next reset.
- R3: A word is stored only at a write-clock edge where `wen_n`=0, `wr_aux`=1 and `full_n`=1. A write attempt while full leaves the stored contents unchanged, and so does any edge with `wr_aux`=0.
- R4: The output register loads the oldest stored word at a read-clock edge where `ren_a_n`=0 and `ren_b_n`=0. If either enable is 1, `dout` holds its value.
- R5: A read request while `empty_n`=0 is ignored. `dout` holds, and the read pointer does not move, so the next word written is the next word read.
- R6: In offset-load mode (`load_mode`=1), a FIFO read additionally requires `wr_aux`=1. With `wr_aux`=0 the read request is ignored and `dout` holds.
- R7: `empty_n`, updated on the read clock, is 0 exactly when the occupancy seen on the read side is zero.
- R8: `full_n`, updated on the write clock, is 0 exactly when the occupancy seen on the write side equals DEPTH.
- R9: `aempty_n` is 0 when the read-side occupancy is less than or equal to `ae_ofs`, and 1 above it.
- R10: `afull_n` is 0 when the write-side occupancy is greater than or equal to DEPTH minus `af_ofs`, and 1 below it.
- R11: `dout_oe` is 1 when `out_en_n` is 0 and 0 when `out_en_n` is 1 (combinational, no clock).
- R12: Words leave in the order they were stored, with their values unchanged, across pointer wrap.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| wr_clk | input | 1 | Write clock |
| rd_clk | input | 1 | Read clock, unrelated to wr_clk |
| rst_n | input | 1 | Active-low reset, sampled synchronously in each domain |
| wen_n | input | 1 | Active-low write enable |
| wr_aux | input | 1 | Second write enable (high = enable) or offset-load steer, role fixed at reset |
| din | input | WIDTH | Write data |
| ren_a_n | input | 1 | First active-low read enable |
| ren_b_n | input | 1 | Second active-low read enable |
| out_en_n | input | 1 | Active-low output enable |
| ae_ofs | input | AW | Almost-empty threshold from the offset block |
| af_ofs | input | AW | Almost-full threshold from the offset block |
| dout | output | WIDTH | Output register contents |
| dout_oe | output | 1 | Drive enable for the pad driver of dout |
| empty_n | output | 1 | Empty flag, active low, read clock |
| aempty_n | output | 1 | Almost-empty flag, active low, read clock |
| full_n | output | 1 | Full flag, active low, write clock |
| afull_n | output | 1 | Almost-full flag, active low, write clock |
| load_mode | output | 1 | 1 when the shared pin acts as offset-load steer |

## Verification
The bench approaches each threshold from one word below it, checking just below and just at the boundary. This exposes an off-by-one in the almost-empty or almost-full comparison: such a design flips one word early or late. It writes one extra word into a full buffer and then drains everything in order. A design that lets the write through would overwrite the oldest word or show a phantom entry after draining. It issues read requests while empty and with only one enable asserted, then writes a fresh word. A read pointer that slipped would return a stale value, and an unheld register would change. Finally, it resets with the shared pin low and checks that reads are steered away by that pin. A design that ignored the mode would return data while the pin is low.

// File: rtl/dc_fifo_pkg.sv
// Shared types for the dual-clock FIFO.
package dc_fifo_pkg;

    // Role of the shared write-side control pin, chosen during reset.
    typedef enum logic {
        PIN_DUAL_EN  = 1'b0,
        PIN_OFS_LOAD = 1'b1
    } pin_mode_e;

endpackage

// File: rtl/dc_fifo_ram.sv
// Storage array: one synchronous write port and one asynchronous read port.
// Assumes: the caller never writes a location it is reading in the same
// read-clock cycle (pointer flags guarantee this).
module dc_fifo_ram #(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             we,
    input  logic [AW-1:0]    waddr,
    input  logic [WIDTH-1:0] wdata,
    input  logic [AW-1:0]    raddr,
    output logic [WIDTH-1:0] rdata
);

    logic [WIDTH-1:0] mem_q [DEPTH];

    // Store the incoming word at the write address.
    always_ff @(posedge wr_clk) begin
        if (we) begin
            mem_q[waddr] <= wdata;
        end
    end

    // Present the word at the read address without a clock.
    assign rdata = mem_q[raddr];

endmodule

// File: rtl/dc_fifo_ptr_xing.sv
// Moves a binary pointer from one clock domain to another.
// The pointer is registered as Gray code in the source domain and passed
// through two flip-flops in the destination domain, then converted back
// to binary there.
// Assumes: the source pointer changes by at most one per source clock.
module dc_fifo_ptr_xing #(
    parameter int PW = 7
) (
    input  logic          src_clk,
    input  logic          src_rst_n,
    input  logic [PW-1:0] src_bin,
    input  logic          dst_clk,
    input  logic          dst_rst_n,
    output logic [PW-1:0] dst_bin
);

    logic [PW-1:0] src_gray_q;
    logic [PW-1:0] meta_q;
    logic [PW-1:0] sync_q;
    logic [PW-1:0] bin_c;

    // Register the Gray form of the source pointer.
    always_ff @(posedge src_clk) begin
        if (!src_rst_n) begin
            src_gray_q <= '0;
        end else begin
            src_gray_q <= src_bin ^ (src_bin >> 1);
        end
    end

    // Two-stage synchroniser in the destination domain.
    always_ff @(posedge dst_clk) begin
        if (!dst_rst_n) begin
            meta_q <= '0;
            sync_q <= '0;
        end else begin
            meta_q <= src_gray_q;
            sync_q <= meta_q;
        end
    end

    // Convert the synchronised Gray value back to binary.
    always_comb begin
        bin_c[PW-1] = sync_q[PW-1];
        for (int i = PW - 2; i >= 0; i--) begin
            bin_c[i] = bin_c[i+1] ^ sync_q[i];
        end
    end

    assign dst_bin = bin_c;

    // R12: the Gray value changes by at most one bit per source cycle.
    p_gray_one_bit_r12: assert property (@(posedge src_clk) disable iff (!src_rst_n)
        $countones(src_gray_q ^ $past(src_gray_q)) <= 1);

endmodule

// File: rtl/dc_fifo_wr_side.sv
// Write-side control: write pointer, full and almost-full flags, and the
// latch that fixes the role of the shared control pin during reset.
// Assumes: rptr_sync is the read pointer already brought into wr_clk.
module dc_fifo_wr_side
    import dc_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          wen_n,
    input  logic          wr_aux,
    input  logic [AW-1:0] af_ofs,
    input  logic [AW:0]   rptr_sync,
    output logic [AW:0]   wptr,
    output logic          mem_we,
    output logic          full_n,
    output logic          afull_n,
    output pin_mode_e     mode
);

    localparam int            PW      = AW + 1;
    localparam logic [PW-1:0] DEPTH_P = PW'(DEPTH);

    logic [PW-1:0] wptr_q;
    logic [PW-1:0] wptr_next;
    logic [PW-1:0] occ_next;
    logic [PW-1:0] af_limit;
    logic          wr_go;
    logic          full_n_q;
    logic          afull_n_q;
    pin_mode_e     mode_q;

    // Decide whether this edge stores a word and what the occupancy becomes.
    always_comb begin
        wr_go     = !wen_n && wr_aux && full_n_q;
        wptr_next = wptr_q + PW'(wr_go);
        occ_next  = wptr_next - rptr_sync;
        af_limit  = DEPTH_P - {1'b0, af_ofs};
    end

    // Advance the pointer and register the write-side flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            wptr_q    <= '0;
            full_n_q  <= 1'b1;
            afull_n_q <= 1'b1;
        end else begin
            wptr_q    <= wptr_next;
            full_n_q  <= (occ_next != DEPTH_P);
            afull_n_q <= (occ_next < af_limit);
        end
    end

    // Latch the shared pin's role while reset is held.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mode_q <= wr_aux ? PIN_DUAL_EN : PIN_OFS_LOAD;
        end
    end

    assign wptr    = wptr_q;
    assign mem_we  = wr_go;
    assign full_n  = full_n_q;
    assign afull_n = afull_n_q;
    assign mode    = mode_q;

    // R3: occupancy never exceeds the depth.
    p_no_overflow_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (wptr_q - rptr_sync) <= DEPTH_P);

    // R8: while the flag says not full, the buffer is not at depth.
    p_full_flag_r8: assert property (@(posedge clk) disable iff (!rst_n)
        full_n_q |-> ((wptr_q - rptr_sync) != DEPTH_P));

    // R1: reset forces both write-side flags inactive.
    p_wr_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (full_n_q && afull_n_q));

    // R2: the pin role stays fixed outside reset.
    p_mode_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
        rst_n |=> $stable(mode_q));

endmodule

// File: rtl/dc_fifo_rd_side.sv
// Read-side control: read pointer, output register, empty and
// almost-empty flags.
// Assumes: wptr_sync is the write pointer already brought into rd_clk;
// mode_rd is the pin role synchronised into rd_clk; wr_aux is held steady
// around reads in offset-load mode.
module dc_fifo_rd_side
    import dc_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             ren_a_n,
    input  logic             ren_b_n,
    input  logic             wr_aux,
    input  pin_mode_e        mode_rd,
    input  logic [AW-1:0]    ae_ofs,
    input  logic [AW:0]      wptr_sync,
    input  logic [WIDTH-1:0] rdata,
    output logic [AW:0]      rptr,
    output logic [WIDTH-1:0] dout,
    output logic             empty_n,
    output logic             aempty_n
);

    localparam int PW = AW + 1;

    logic [PW-1:0]    rptr_q;
    logic [PW-1:0]    rptr_next;
    logic [PW-1:0]    occ_next;
    logic [WIDTH-1:0] dout_q;
    logic             rd_go;
    logic             steer_ok;
    logic             empty_n_q;
    logic             aempty_n_q;

    // Decide whether this edge takes a word and what the occupancy becomes.
    always_comb begin
        steer_ok  = (mode_rd == PIN_DUAL_EN) || wr_aux;
        rd_go     = !ren_a_n && !ren_b_n && empty_n_q && steer_ok;
        rptr_next = rptr_q + PW'(rd_go);
        occ_next  = wptr_sync - rptr_next;
    end

    // Advance the pointer, load the output register and register the flags.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rptr_q     <= '0;
            dout_q     <= '0;
            empty_n_q  <= 1'b0;
            aempty_n_q <= 1'b0;
        end else begin
            rptr_q     <= rptr_next;
            if (rd_go) begin
                dout_q <= rdata;
            end
            empty_n_q  <= (occ_next != '0);
            aempty_n_q <= (occ_next > {1'b0, ae_ofs});
        end
    end

    assign rptr     = rptr_q;
    assign dout     = dout_q;
    assign empty_n  = empty_n_q;
    assign aempty_n = aempty_n_q;

    // R4: with either enable high the output register holds.
    p_hold_out_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (ren_a_n || ren_b_n) |=> $stable(dout_q));

    // R7: while the flag says not empty, the pointers differ.
    p_empty_flag_r7: assert property (@(posedge clk) disable iff (!rst_n)
        empty_n_q |-> (rptr_q != wptr_sync));

    // R5: with the flag showing empty, the output register holds.
    p_empty_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
        !empty_n_q |=> $stable(dout_q));

    // R1: reset clears the output and asserts both read-side flags.
    p_rd_reset_r1: assert property (@(posedge clk)
        !rst_n |=> (!empty_n_q && !aempty_n_q && (dout_q == '0)));

endmodule

// File: rtl/dc_fifo_pflag.sv
// Top of the dual-clock FIFO with programmable threshold flags.
// Ties the write side, read side, storage array and the two pointer
// crossings together. The offsets come from a neighbouring register block.
// Assumes: rst_n is held low for several cycles of both clocks.
module dc_fifo_pflag
    import dc_fifo_pkg::*;
#(
    parameter int DEPTH = 64,
    parameter int WIDTH = 9,
    parameter int AW    = $clog2(DEPTH)
) (
    input  logic             wr_clk,
    input  logic             rd_clk,
    input  logic             rst_n,
    input  logic             wen_n,
    input  logic             wr_aux,
    input  logic [WIDTH-1:0] din,
    input  logic             ren_a_n,
    input  logic             ren_b_n,
    input  logic             out_en_n,
    input  logic [AW-1:0]    ae_ofs,
    input  logic [AW-1:0]    af_ofs,
    output logic [WIDTH-1:0] dout,
    output logic             dout_oe,
    output logic             empty_n,
    output logic             aempty_n,
    output logic             full_n,
    output logic             afull_n,
    output logic             load_mode
);

    localparam int PW = AW + 1;

    logic [PW-1:0]    wptr;
    logic [PW-1:0]    rptr;
    logic [PW-1:0]    wptr_at_rd;
    logic [PW-1:0]    rptr_at_wr;
    logic             mem_we;
    logic [WIDTH-1:0] rdata;
    pin_mode_e        mode_wr;
    pin_mode_e        mode_meta_q;
    pin_mode_e        mode_rd_q;

    dc_fifo_wr_side #(.DEPTH(DEPTH), .AW(AW)) u_wr (
        .clk       (wr_clk),
        .rst_n     (rst_n),
        .wen_n     (wen_n),
        .wr_aux    (wr_aux),
        .af_ofs    (af_ofs),
        .rptr_sync (rptr_at_wr),
        .wptr      (wptr),
        .mem_we    (mem_we),
        .full_n    (full_n),
        .afull_n   (afull_n),
        .mode      (mode_wr)
    );

    dc_fifo_ram #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_ram (
        .wr_clk (wr_clk),
        .we     (mem_we),
        .waddr  (wptr[AW-1:0]),
        .wdata  (din),
        .raddr  (rptr[AW-1:0]),
        .rdata  (rdata)
    );

    dc_fifo_ptr_xing #(.PW(PW)) u_w2r (
        .src_clk   (wr_clk),
        .src_rst_n (rst_n),
        .src_bin   (wptr),
        .dst_clk   (rd_clk),
        .dst_rst_n (rst_n),
        .dst_bin   (wptr_at_rd)
    );

    dc_fifo_ptr_xing #(.PW(PW)) u_r2w (
        .src_clk   (rd_clk),
        .src_rst_n (rst_n),
        .src_bin   (rptr),
        .dst_clk   (wr_clk),
        .dst_rst_n (rst_n),
        .dst_bin   (rptr_at_wr)
    );

    // Bring the static pin role into the read domain.
    always_ff @(posedge rd_clk) begin
        mode_meta_q <= mode_wr;
        mode_rd_q   <= mode_meta_q;
    end

    dc_fifo_rd_side #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) u_rd (
        .clk       (rd_clk),
        .rst_n     (rst_n),
        .ren_a_n   (ren_a_n),
        .ren_b_n   (ren_b_n),
        .wr_aux    (wr_aux),
        .mode_rd   (mode_rd_q),
        .ae_ofs    (ae_ofs),
        .wptr_sync (wptr_at_rd),
        .rdata     (rdata),
        .rptr      (rptr),
        .dout      (dout),
        .empty_n   (empty_n),
        .aempty_n  (aempty_n)
    );

    assign dout_oe   = !out_en_n;
    assign load_mode = (mode_wr == PIN_OFS_LOAD);

    // R11: the drive enable always mirrors the output-enable pin.
    p_oe_follow_r11: assert property (@(posedge rd_clk) disable iff (!rst_n)
        dout_oe != out_en_n);

endmodule

// File: tb/dc_fifo_pflag_tb_top.sv
// Directed bench for the dual-clock FIFO, one task per scenario.
module dc_fifo_pflag_tb_top;

    localparam int DEPTH = 64;
    localparam int WIDTH = 9;
    localparam int AW    = 6;

    logic             wr_clk = 1'b0;
    logic             rd_clk = 1'b0;
    logic             rst_n  = 1'b0;
    logic             wen_n  = 1'b1;
    logic             wr_aux = 1'b1;
    logic [WIDTH-1:0] din    = '0;
    logic             ren_a_n = 1'b1;
    logic             ren_b_n = 1'b1;
    logic             out_en_n = 1'b0;
    logic [AW-1:0]    ae_ofs = 6'd7;
    logic [AW-1:0]    af_ofs = 6'd7;
    logic [WIDTH-1:0] dout;
    logic             dout_oe;
    logic             empty_n;
    logic             aempty_n;
    logic             full_n;
    logic             afull_n;
    logic             load_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 wr_clk = ~wr_clk;
    always #6.5 rd_clk = ~rd_clk;

    dc_fifo_pflag #(.DEPTH(DEPTH), .WIDTH(WIDTH), .AW(AW)) dut_i (
        .wr_clk (wr_clk), .rd_clk (rd_clk), .rst_n (rst_n),
        .wen_n (wen_n), .wr_aux (wr_aux), .din (din),
        .ren_a_n (ren_a_n), .ren_b_n (ren_b_n), .out_en_n (out_en_n),
        .ae_ofs (ae_ofs), .af_ofs (af_ofs),
        .dout (dout), .dout_oe (dout_oe), .empty_n (empty_n),
        .aempty_n (aempty_n), .full_n (full_n), .afull_n (afull_n),
        .load_mode (load_mode)
    );

    function automatic logic [WIDTH-1:0] pat(input int i);
        return WIDTH'((i * 37 + 11) % 512);
    endfunction

    task automatic chk(input string req, input string what, input int got, input int exp);
        total++;
        if (got != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, got, exp);
        end
    endtask

    task automatic wr(input logic [WIDTH-1:0] d);
        @(negedge wr_clk);
        din   = d;
        wen_n = 1'b0;
        @(negedge wr_clk);
        wen_n = 1'b1;
    endtask

    task automatic rd();
        @(negedge rd_clk);
        ren_a_n = 1'b0;
        ren_b_n = 1'b0;
        @(negedge rd_clk);
        ren_a_n = 1'b1;
        ren_b_n = 1'b1;
    endtask

    task automatic settle();
        repeat (6) @(negedge rd_clk);
        repeat (4) @(negedge wr_clk);
    endtask

    task automatic do_reset(input logic aux);
        wr_aux = aux;
        rst_n  = 1'b0;
        repeat (10) @(negedge wr_clk);
        rst_n = 1'b1;
        settle();
    endtask

    task automatic t_reset();
        do_reset(1'b1);
        chk("R1", "empty_n", empty_n, 0);
        chk("R1", "aempty_n", aempty_n, 0);
        chk("R1", "full_n", full_n, 1);
        chk("R1", "afull_n", afull_n, 1);
        chk("R1", "dout", dout, 0);
        chk("R2", "load_mode dual", load_mode, 0);
    endtask

    task automatic t_basic();
        wr(9'h1A5); wr(9'h05A); wr(9'h1FF);
        settle();
        chk("R7", "empty_n with 3", empty_n, 1);
        chk("R9", "aempty_n with 3", aempty_n, 0);
        rd();
        chk("R4", "first word", dout, 9'h1A5);
        @(negedge rd_clk); ren_a_n = 1'b0; ren_b_n = 1'b1;
        @(negedge rd_clk); ren_a_n = 1'b1;
        @(negedge rd_clk); ren_a_n = 1'b1; ren_b_n = 1'b0;
        @(negedge rd_clk); ren_b_n = 1'b1;
        chk("R4", "hold one enable", dout, 9'h1A5);
        rd(); rd();
        chk("R12", "third word", dout, 9'h1FF);
        settle();
        chk("R7", "empty_n drained", empty_n, 0);
        rd();
        chk("R5", "read while empty", dout, 9'h1FF);
        wr(9'h0AA);
        settle();
        rd();
        chk("R5", "next after empty read", dout, 9'h0AA);
        settle();
    endtask

    task automatic t_gate();
        @(negedge wr_clk); wr_aux = 1'b0; wen_n = 1'b0; din = 9'h155;
        @(negedge wr_clk); wen_n = 1'b1; wr_aux = 1'b1;
        settle();
        chk("R3", "aux low blocks write", empty_n, 0);
    endtask

    task automatic t_levels();
        int errs = 0;
        for (int i = 0; i < 7; i++) wr(pat(i));
        settle();
        chk("R9", "aempty_n at 7", aempty_n, 0);
        wr(pat(7));
        settle();
        chk("R9", "aempty_n at 8", aempty_n, 1);
        for (int i = 8; i < 56; i++) wr(pat(i));
        settle();
        chk("R10", "afull_n at 56", afull_n, 1);
        wr(pat(56));
        settle();
        chk("R10", "afull_n at 57", afull_n, 0);
        for (int i = 57; i < 63; i++) wr(pat(i));
        settle();
        chk("R8", "full_n at 63", full_n, 1);
        wr(pat(63));
        settle();
        chk("R8", "full_n at 64", full_n, 0);
        wr(9'h1EE);
        settle();
        chk("R3", "full_n after extra", full_n, 0);
        for (int i = 0; i < DEPTH; i++) begin
            rd();
            if (dout != pat(i)) errs++;
        end
        chk("R12", "order mismatches", errs, 0);
        settle();
        chk("R7", "empty after drain", empty_n, 0);
        chk("R8", "full_n after drain", full_n, 1);
        rd();
        chk("R3", "extra word absent", dout, pat(63));
    endtask

    task automatic t_offsets();
        ae_ofs = 6'd2;
        af_ofs = 6'd3;
        wr(pat(100)); wr(pat(101));
        settle();
        chk("R9", "aempty_n at ofs 2", aempty_n, 0);
        wr(pat(102));
        settle();
        chk("R9", "aempty_n above ofs 2", aempty_n, 1);
        for (int i = 3; i < 60; i++) wr(pat(100 + i));
        settle();
        chk("R10", "afull_n at 60 ofs 3", afull_n, 1);
        wr(pat(160));
        settle();
        chk("R10", "afull_n at 61 ofs 3", afull_n, 0);
        for (int i = 0; i < 61; i++) rd();
        settle();
        chk("R12", "last word ofs test", dout, pat(160));
        ae_ofs = 6'd7;
        af_ofs = 6'd7;
        settle();
    endtask

    task automatic t_oe();
        out_en_n = 1'b1;
        #1;
        chk("R11", "oe off", dout_oe, 0);
        out_en_n = 1'b0;
        #1;
        chk("R11", "oe on", dout_oe, 1);
    endtask

    task automatic t_load_mode();
        do_reset(1'b0);
        chk("R2", "load_mode set", load_mode, 1);
        wr(9'h0F0);
        settle();
        chk("R3", "steer low no store", empty_n, 0);
        wr_aux = 1'b1;
        wr(9'h123);
        settle();
        chk("R3", "steer high stores", empty_n, 1);
        wr_aux = 1'b0;
        settle();
        rd();
        chk("R6", "read steered away", dout, 0);
        wr_aux = 1'b1;
        settle();
        rd();
        chk("R6", "read with steer high", dout, 9'h123);
    endtask

    initial begin
        t_reset();
        t_basic();
        t_gate();
        t_levels();
        t_offsets();
        t_oe();
        t_load_mode();
        if (!done) begin
            done = 1'b1;
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        #1_000_000;
        if (!done) begin
            done = 1'b1;
            total++;
            bad++;
            $display("FAIL watchdog: actual=timeout expected=completion");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule